// File: doc/BRIEF.md
# Event Mapping Command Executor

This block carries out one event-mapping command taken from a command queue held in memory. On a start pulse it reads the three doublewords of the command at the queue base plus the given offset. From them it takes the device number, the event number, the requested interrupt number and the collection number. It then asks a table-walker port for the device's entry. The entry supplies a valid flag, an event-range size and the base of the per-device translation table.

The command comes in two forms, chosen by a mode input sampled with the start pulse. The explicit form stores the requested interrupt number. The implicit form ignores that field and stores the event number as the interrupt number. A command that passes every range check causes a 12-byte translation entry to be written at its event's slot: an 8-byte low word first, then a 4-byte high word. A command that fails any check writes nothing and completes with failure, so the queue logic upstream can move on to the next command.

Top module: `evmap_exec`

## Requirements
- R1: After `start`, the block reads 8-byte words at `q_base+cmd_off`, `+8` and `+16`, in that order. It then requests the device entry with `dev_id` equal to bits [63:32] of the first word. The event number is bits [31:0] of the second word, the requested interrupt number is bits [63:32] of the second word, and the collection number is bits [15:0] of the third word.
- R2: For an accepted explicit-form command, the low word written is: bit 0 = 1 (valid), bit 1 = 1 (physical type), bits [25:2] = interrupt number, bits [35:26] = 1023, all other bits 0. The high word written is the 16-bit collection number, zero-extended to 32 bits.
- R3: In the implicit form (`use_event_id`=1), bits [63:32] of the second word have no effect. The stored interrupt number is the event number, and no interrupt range check applies.
- R4: The entry address is `{dev_entry[AW-3:6], 8'h00} + 12*event`. The low word is written as 8 bytes (`mem_dw`=1) at that address, and the high word as 4 bytes (`mem_dw`=0) at address+8.
- R5: With S = `dev_entry[5:1]`, an event number greater than 2^(S+1) is rejected. An event number equal to 2^(S+1) is accepted.
- R6: The command is rejected, with no write, if the device number exceeds `MAX_DEV`, the collection number exceeds `MAX_COLL`, or `dev_entry[0]` is 0.
- R7: In the explicit form, an interrupt number below 8192 or above 2^(ID_BITS+1)-1 is rejected, except for the value 1023, which is accepted.
- R8: An error response on any command read or on the device fetch ends the command with `done`=1 and `ok`=0, and no write is made.
- R9: An error on the low-word write skips the high-word write and ends with `ok`=0. An error on the high-word write also ends with `ok`=0.
- R10: `done` is a one-cycle pulse at the end of every command. `ok` is 1 only when both writes completed without error. A `start` pulse arriving while a command is in progress is ignored.
- R11: During and right after reset, `done`, `mem_req` and `dev_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one command; ignored while busy |
| use_event_id | input | 1 | 1 = implicit form (event number stored as interrupt number) |
| q_base | input | AW | Command queue base address |
| cmd_off | input | OFF_W | Offset of the command within the queue |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_dw | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 64 | Write data (4-byte writes use bits [31:0]) |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Completed request failed (valid with `mem_ack`) |
| mem_rdata | input | 64 | Read data (valid with `mem_ack`) |
| dev_req | output | 1 | Device entry request, held until `dev_ack` |
| dev_id | output | 32 | Device number to look up |
| dev_ack | input | 1 | Device entry lookup completed |
| dev_err | input | 1 | Device lookup failed (valid with `dev_ack`) |
| dev_entry | input | 64 | Device entry (valid with `dev_ack`) |
| done | output | 1 | One-cycle end-of-command pulse |
| ok | output | 1 | Command succeeded (valid with `done`) |

## Verification
The properties assume that the memory and table-walker agents answer only a pending request, with a single-cycle acknowledge. They also assume that the response fields are meaningful only in the cycle of that acknowledge. The bench's responders act on a falling edge only while the matching request is high, and they drop the acknowledge one cycle after raising it, so every handshake the design sees has this form. Error responses are injected at one chosen address or device number per command. Commands are started only after the previous `done`, except for one deliberate overlapping start pulse.

// File: rtl/evmap_exec.sv
module evmap_exec #(
  parameter int AW = 48,
  parameter int OFF_W = 20,
  parameter logic [31:0] MAX_DEV = 32'h0000_FFFF,
  parameter logic [15:0] MAX_COLL = 16'h00FF,
  parameter int ID_BITS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          use_event_id,
  input  logic [AW-1:0] q_base,
  input  logic [OFF_W-1:0] cmd_off,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dw,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [63:0]   mem_rdata,
  output logic          dev_req,
  output logic [31:0]   dev_id,
  input  logic          dev_ack,
  input  logic          dev_err,
  input  logic [63:0]   dev_entry,
  output logic          done,
  output logic          ok
);
  localparam logic [32:0] INT_LIM = (33'd1 << (ID_BITS + 1)) - 33'd1;
  localparam logic [31:0] LPI_MIN = 32'd8192;
  localparam logic [31:0] SPUR_ID = 32'd1023;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_DEV, S_CHK, S_WRL, S_WRH, S_FIN
  } st_t;

  st_t st;
  logic [AW-1:0] cmd_addr;
  logic [31:0]   ev_id, int_id;
  logic [15:0]   icid;
  logic [63:0]   dte;
  logic          impl, ok_r;

  logic [AW-1:0] itt_base, ent_addr;
  logic [32:0]   ev_lim;
  logic [23:0]   id_store;
  logic [63:0]   lo_word;
  logic          int_bad, reject;

  assign itt_base = {dte[AW-3:6], 8'h00};
  assign ent_addr = itt_base + AW'(36'(ev_id) * 36'd12);
  assign ev_lim   = 33'd1 << (6'(dte[5:1]) + 6'd1);
  assign id_store = impl ? ev_id[23:0] : int_id[23:0];
  assign lo_word  = {28'd0, SPUR_ID[9:0], id_store, 1'b1, 1'b1};

  assign int_bad = !impl && (int_id != SPUR_ID) &&
                   ((int_id < LPI_MIN) || ({1'b0, int_id} > INT_LIM));
  assign reject  = (dev_id > MAX_DEV) || (icid > MAX_COLL) || !dte[0] ||
                   ({1'b0, ev_id} > ev_lim) || int_bad;

  assign mem_req = (st == S_RD0) || (st == S_RD1) || (st == S_RD2) ||
                   (st == S_WRL) || (st == S_WRH);
  assign mem_we  = (st == S_WRL) || (st == S_WRH);
  assign mem_dw  = (st != S_WRH);
  assign dev_req = (st == S_DEV);
  assign done    = (st == S_FIN);
  assign ok      = done && ok_r;

  always_comb begin
    mem_addr  = cmd_addr;
    mem_wdata = 64'd0;
    case (st)
      S_RD1: mem_addr = cmd_addr + AW'(8);
      S_RD2: mem_addr = cmd_addr + AW'(16);
      S_WRL: begin
        mem_addr  = ent_addr;
        mem_wdata = lo_word;
      end
      S_WRH: begin
        mem_addr  = ent_addr + AW'(8);
        mem_wdata = {48'd0, icid};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cmd_addr <= '0;
      dev_id   <= '0;
      ev_id    <= '0;
      int_id   <= '0;
      icid     <= '0;
      dte      <= '0;
      impl     <= 1'b0;
      ok_r     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cmd_addr <= q_base + AW'(cmd_off);
          impl     <= use_event_id;
          ok_r     <= 1'b0;
          st       <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          dev_id <= mem_rdata[63:32];
          st     <= mem_err ? S_FIN : S_RD1;
        end
        S_RD1: if (mem_ack) begin
          ev_id  <= mem_rdata[31:0];
          int_id <= mem_rdata[63:32];
          st     <= mem_err ? S_FIN : S_RD2;
        end
        S_RD2: if (mem_ack) begin
          icid <= mem_rdata[15:0];
          st   <= mem_err ? S_FIN : S_DEV;
        end
        S_DEV: if (dev_ack) begin
          dte <= dev_entry;
          st  <= dev_err ? S_FIN : S_CHK;
        end
        S_CHK: st <= reject ? S_FIN : S_WRL;
        S_WRL: if (mem_ack) st <= mem_err ? S_FIN : S_WRH;
        S_WRH: if (mem_ack) begin
          ok_r <= !mem_err;
          st   <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evmap_exec_chk.sv
module evmap_exec_chk #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_dw,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          dev_req,
  input logic          done,
  input logic          ok
);
  logic [AW-1:0] lo_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) lo_addr <= '0;
    else if (mem_req && mem_we && mem_dw && mem_ack) lo_addr <= mem_addr;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_dw |-> mem_addr == lo_addr + AW'(8)); // R4

  AST_SKIP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && mem_err && mem_we && mem_dw |=> !(mem_req && mem_we)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done); // R10

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dev_req)); // R1

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !dev_req); // R10
endmodule

bind evmap_exec evmap_exec_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_dw(mem_dw), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .mem_err(mem_err), .dev_req(dev_req), .done(done), .ok(ok)
);

// File: tb/sim_evmap_exec.sv
module sim_evmap_exec;
  localparam int AW = 16;
  localparam int OFF_W = 12;

  logic clk = 0, rst_n = 0;
  logic start = 0, use_event_id = 0;
  logic [AW-1:0] q_base = '0;
  logic [OFF_W-1:0] cmd_off = '0;
  logic mem_req, mem_we, mem_dw, mem_ack = 0, mem_err = 0;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic dev_req, dev_ack = 0, dev_err = 0;
  logic [31:0] dev_id;
  logic [63:0] dev_entry = '0;
  logic done, ok;

  always #5 clk = ~clk;

  evmap_exec #(.AW(AW), .OFF_W(OFF_W), .MAX_DEV(32'd15), .MAX_COLL(16'd31),
               .ID_BITS(13)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .use_event_id(use_event_id),
    .q_base(q_base), .cmd_off(cmd_off), .mem_req(mem_req), .mem_we(mem_we),
    .mem_dw(mem_dw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_id(dev_id), .dev_ack(dev_ack), .dev_err(dev_err),
    .dev_entry(dev_entry), .done(done), .ok(ok));

  logic [7:0]  mem [0:4095];
  logic [63:0] dtab [0:31];
  int err_addr = -1;
  int err_dev = -1;
  int n_chk = 0, n_bad = 0, n_done = 0;
  bit finished = 0;

  typedef struct {
    bit exp_ok;
    int eaddr;
    logic [63:0] elo;
    logic [31:0] ehi;
    string tag;
  } item_t;
  item_t sb[$];

  function automatic logic [63:0] rd64(int a);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mem[(a + i) & 12'hFFF];
    return v;
  endfunction

  function automatic logic [31:0] rd32(int a);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[i*8 +: 8] = mem[(a + i) & 12'hFFF];
    return v;
  endfunction

  task automatic wr64(int a, logic [63:0] v);
    for (int i = 0; i < 8; i++) mem[(a + i) & 12'hFFF] = v[i*8 +: 8];
  endtask

  task automatic check(bit cond, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // memory responder
  initial forever begin
    @(negedge clk);
    if (mem_req && !mem_ack) begin
      mem_ack = 1;
      mem_err = (int'(mem_addr) == err_addr);
      mem_rdata = rd64(int'(mem_addr));
      if (mem_we && !mem_err) begin
        if (mem_dw) wr64(int'(mem_addr), mem_wdata);
        else for (int i = 0; i < 4; i++) mem[(int'(mem_addr) + i) & 12'hFFF] = mem_wdata[i*8 +: 8];
      end
    end else begin
      mem_ack = 0;
      mem_err = 0;
    end
  end

  // table-walker responder
  initial forever begin
    @(negedge clk);
    if (dev_req && !dev_ack) begin
      dev_ack = 1;
      dev_err = (int'(dev_id) == err_dev);
      dev_entry = (dev_id < 32) ? dtab[dev_id[4:0]] : 64'd0;
    end else begin
      dev_ack = 0;
      dev_err = 0;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      n_done++;
      if (sb.size() == 0) begin
        check(0, "R10 unexpected done", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(ok == it.exp_ok, {it.tag, " ok"}, 64'(ok), 64'(it.exp_ok));
        check(rd64(it.eaddr) == it.elo, {it.tag, " low word"}, rd64(it.eaddr), it.elo);
        check(rd32(it.eaddr + 8) == it.ehi, {it.tag, " high word"}, 64'(rd32(it.eaddr + 8)), 64'(it.ehi));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 64'd0, 64'd1);
    summary();
  end

  function automatic logic [63:0] mk_dte(bit v, int sz, int base_blk);
    return (64'(base_blk) << 6) | (64'(sz & 31) << 1) | 64'(v);
  endfunction

  task automatic run_cmd(string tag, bit impl, int devid, int ev, int pint,
                         int icid, int off, int e_addr, int e_dev, bit poke);
    item_t it;
    logic [63:0] dte;
    int sz, base, ea, prev;
    bit valid, rd_fail;
    logic [23:0] sid;
    wr64(off,      {32'(devid), 32'h0});
    wr64(off + 8,  {32'(pint), 32'(ev)});
    wr64(off + 16, {48'hABCD_0000_0000, 16'(icid)});
    dte  = (devid >= 0 && devid < 32) ? dtab[devid] : 64'd0;
    sz   = int'(dte[5:1]);
    base = int'(dte[13:6]) << 8;
    ea   = base + 12 * ev;
    valid = (devid <= 15) && (icid <= 31) && dte[0] &&
            (longint'(ev) <= (longint'(1) << (sz + 1))) &&
            (impl || pint == 1023 || (pint >= 8192 && pint <= 16383));
    rd_fail = (e_addr == off) || (e_addr == off + 8) || (e_addr == off + 16) ||
              (e_dev == devid);
    it.tag = tag;
    it.eaddr = ea;
    it.elo = rd64(ea);
    it.ehi = rd32(ea + 8);
    sid = impl ? ev[23:0] : pint[23:0];
    if (rd_fail || !valid) it.exp_ok = 0;
    else if (e_addr == ea) it.exp_ok = 0;
    else begin
      it.elo = {28'd0, 10'd1023, sid, 2'b11};
      if (e_addr == ea + 8) it.exp_ok = 0;
      else begin
        it.exp_ok = 1;
        it.ehi = {16'd0, 16'(icid)};
      end
    end
    sb.push_back(it);
    err_addr = e_addr;
    err_dev = e_dev;
    prev = n_done;
    @(negedge clk);
    start = 1; use_event_id = impl; cmd_off = OFF_W'(off);
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1; cmd_off = OFF_W'(off + 32);
      @(negedge clk);
      start = 0;
    end
    while (n_done == prev) @(negedge clk);
    repeat (4) @(negedge clk);
    err_addr = -1;
    err_dev = -1;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 32; i++) dtab[i] = mk_dte(1, 4, 4);
    dtab[3] = mk_dte(1, 4, 8);
    dtab[4] = mk_dte(1, 0, 12);
    dtab[5] = mk_dte(0, 4, 4);
    repeat (3) @(negedge clk);
    check(done == 0, "R11 done in reset", 64'(done), 0);
    check(mem_req == 0, "R11 mem_req in reset", 64'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    check(dev_req == 0, "R11 dev_req after reset", 64'(dev_req), 0);
    check(done == 0, "R11 done after reset", 64'(done), 0);

    run_cmd("R1 R2 explicit map",        0, 2, 5, 8200, 7, 0,   -1, -1, 0);
    run_cmd("R3 implicit ignores intid", 1, 2, 9, 5, 3, 32,     -1, -1, 0);
    run_cmd("R4 R6 other base max coll", 0, 3, 0, 9000, 31, 64, -1, -1, 0);
    run_cmd("R5 event at limit",         0, 4, 2, 8192, 1, 96,  -1, -1, 0);
    run_cmd("R5 event over limit",       0, 4, 3, 8192, 1, 128, -1, -1, 0);
    run_cmd("R6 device over max",        0, 16, 6, 8192, 1, 160, -1, -1, 0);
    run_cmd("R6 collection over max",    0, 2, 7, 8192, 32, 192, -1, -1, 0);
    run_cmd("R6 invalid device entry",   0, 5, 8, 8192, 1, 224, -1, -1, 0);
    run_cmd("R7 intid 8191",             0, 2, 10, 8191, 1, 256, -1, -1, 0);
    run_cmd("R7 intid 16383",            0, 2, 11, 16383, 2, 288, -1, -1, 0);
    run_cmd("R7 intid 16384",            0, 2, 12, 16384, 2, 320, -1, -1, 0);
    run_cmd("R7 spurious 1023",          0, 2, 13, 1023, 2, 352, -1, -1, 0);
    run_cmd("R7 intid 1022",             0, 2, 14, 1022, 2, 384, -1, -1, 0);
    run_cmd("R8 read error word1",       0, 2, 15, 8192, 2, 416, 424, -1, 0);
    run_cmd("R8 device fetch error",     0, 2, 16, 8192, 2, 448, -1, 2, 0);
    run_cmd("R9 low write error",        0, 2, 17, 8192, 2, 480, 1024 + 12*17, -1, 0);
    run_cmd("R9 high write error",       0, 2, 18, 8192, 2, 512, 1024 + 12*18 + 8, -1, 0);
    run_cmd("R10 start while busy",      0, 2, 19, 8300, 4, 544, -1, -1, 1);
    run_cmd("R3 implicit at limit",      1, 4, 2, 0, 5, 608, -1, -1, 0);

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R10 pending results", 64'(sb.size()), 0);
    summary();
  end
endmodule